// File: doc/BRIEF.md
# Interrupt Acceptance and Exception Entry Sequencer

This block sits on the processor side of an interrupt path. Each cycle it is idle, it compares the pending request level from an interrupt controller with the three-bit priority mask in its status word and with the level it is already servicing. It then decides whether to take the interrupt. When it takes one, it asks the controller for a vector number. Internal exceptions use the same entry path: a software trap with a four-bit operand, a divide by a zero divisor, and a trap on overflow.

Every entry follows the same fixed sequence over a simple one-transfer-at-a-time memory port. The block saves the return address and then the old status word on a downward-growing stack. After that it sets the privileged-mode flag and clears the single-step flag. Interrupt entries also raise the mask to the accepted level. Last, it reads the handler address from a vector table. A load port lets surrounding logic, such as an exception-return path, set the status word, program counter, stack pointer, table base and serviced level while the sequencer is idle.

Top module: `irq_entry_seq`

## Requirements
- R1: After reset the status word is 0x2700, the program counter, stack pointer, table base and serviced level are 0, and busy, ack_req and mem_req are low.
- R2: A nonzero pending level is taken when it is above the status mask in bits 10:8 or equals 7, and it is also at least the serviced level. The block then asserts ack_req with ack_lvl equal to that level, and the serviced level becomes it.
- R3: A pending level that is not above the mask (other than 7), or that is below the serviced level, starts nothing: busy and ack_req stay low.
- R4: The first entry transfer is a 32-bit write of the program counter to stack pointer minus 4. The second is a 16-bit write of the unchanged status word to stack pointer minus 6. The stack pointer ends 6 lower.
- R5: Only after the status word write is acknowledged is bit 13 (privileged) set and bit 15 (single-step) cleared. For internal exceptions the mask bits 10:8 keep their value.
- R6: For interrupt entries the mask bits 10:8 are replaced by the accepted level.
- R7: The last transfer is a 32-bit read at table base plus vector number times 4. The read word, with its most significant byte at the lowest address, becomes the program counter, and busy falls.
- R8: exc_kind 00 gives vector 32 plus exc_arg, 01 gives vector 5 (zero divisor), and 10 or 11 gives vector 7 (trap on overflow). An interrupt uses the ack_vec returned with ack_done.
- R9: From acceptance until the vector read completes, busy is high, and exception requests, pending levels and loads are ignored.
- R10: If an exception request and an acceptable interrupt arrive in the same idle cycle, the exception is entered first.
- R11: A load pulse while idle, with no entry starting, sets the status word, program counter, stack pointer, table base and serviced level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pend_lvl | input | 3 | Pending interrupt level, 0 means none |
| ack_req | output | 1 | Acknowledge request to the interrupt controller |
| ack_lvl | output | 3 | Level being acknowledged |
| ack_done | input | 1 | Controller has answered the acknowledge |
| ack_vec | input | 8 | Vector number supplied with ack_done |
| exc_req | input | 1 | Single-cycle internal exception request |
| exc_kind | input | 2 | Exception kind: 00 trap, 01 zero divisor, 1x overflow trap |
| exc_arg | input | 4 | Trap operand |
| mem_req | output | 1 | Memory transfer request |
| mem_we | output | 1 | 1 for write, 0 for read |
| mem_long | output | 1 | 1 for 32-bit transfer, 0 for 16-bit |
| mem_addr | output | 32 | Byte address of the transfer |
| mem_wdata | output | 32 | Write data, 16-bit writes in the low half |
| mem_rdata | input | 32 | Read data |
| mem_ack | input | 1 | Transfer completes at this clock edge |
| ld_en | input | 1 | Load pulse for the state registers |
| ld_sr | input | 16 | Status word to load |
| ld_pc | input | 32 | Program counter to load |
| ld_sp | input | 32 | Stack pointer to load |
| ld_vbr | input | 32 | Vector table base to load |
| ld_lvl | input | 3 | Serviced level to load |
| busy | output | 1 | Entry sequence in progress |
| sr_q | output | 16 | Current status word |
| pc_q | output | 32 | Current program counter |
| sp_q | output | 32 | Current stack pointer |
| cur_lvl | output | 3 | Level currently being serviced |

## Verification
The properties assume that the memory side raises mem_ack only while mem_req is high, and that the controller raises ack_done only while ack_req is high. They also assume exc_req is a single-cycle pulse. The bench's memory model answers each request in the cycle it sees it. Its controller model answers only an active acknowledge, and the pending level drops once it has been acknowledged. Loads and exception pulses are driven for exactly one cycle and land on the falling clock edge.

// File: rtl/irq_entry_pkg.sv
package irq_entry_pkg;
  localparam int SR_W     = 16;
  localparam int SR_SUP   = 13;
  localparam int SR_STEP  = 15;
  localparam int SR_MLO   = 8;
  localparam logic [SR_W-1:0] SR_AT_RESET = 16'h2700;

  localparam logic [7:0] VEC_TRAP0  = 8'd32;
  localparam logic [7:0] VEC_ZERO   = 8'd5;
  localparam logic [7:0] VEC_OVFL   = 8'd7;

  typedef enum logic [2:0] {
    SQ_IDLE, SQ_ACK, SQ_SAVE_PC, SQ_SAVE_SR, SQ_VFETCH
  } seq_st_t;

  // Vector number for an internal exception request
  function automatic logic [7:0] exc_vector(input logic [1:0] kind,
                                            input logic [3:0] arg);
    case (kind)
      2'd0:    return VEC_TRAP0 + {4'd0, arg};
      2'd1:    return VEC_ZERO;
      default: return VEC_OVFL;
    endcase
  endfunction
endpackage

// File: rtl/irq_accept.sv
module irq_accept #(
  parameter int LW = 3
) (
  input  logic [LW-1:0] pend,
  input  logic [LW-1:0] mask,
  input  logic [LW-1:0] serviced,
  output logic          take
);
  localparam logic [LW-1:0] TOP_LVL = '1;

  logic above_mask;
  logic not_below;

  always_comb begin
    above_mask = (pend > mask) || (pend == TOP_LVL);
    not_below  = (pend >= serviced);
    take       = (pend != '0) && above_mask && not_below;
  end
endmodule

// File: rtl/entry_fsm.sv
module entry_fsm
  import irq_entry_pkg::*;
#(
  parameter int AW = 32,
  parameter int LW = 3,
  parameter int VW = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            take_irq,
  input  logic [LW-1:0]   pend_lvl,
  input  logic            exc_req,
  input  logic [1:0]      exc_kind,
  input  logic [3:0]      exc_arg,
  input  logic            ack_done,
  input  logic [VW-1:0]   ack_vec,
  input  logic            mem_ack,
  input  logic [AW-1:0]   mem_rdata,
  input  logic            ld_en,
  input  logic [SR_W-1:0] ld_sr,
  input  logic [AW-1:0]   ld_pc,
  input  logic [AW-1:0]   ld_sp,
  input  logic [AW-1:0]   ld_vbr,
  input  logic [LW-1:0]   ld_lvl,
  output logic            busy,
  output logic            ack_req,
  output logic [LW-1:0]   ack_lvl,
  output logic            mem_req,
  output logic            mem_we,
  output logic            mem_long,
  output logic [AW-1:0]   mem_addr,
  output logic [AW-1:0]   mem_wdata,
  output logic [SR_W-1:0] sr_q,
  output logic [AW-1:0]   pc_q,
  output logic [AW-1:0]   sp_q,
  output logic [LW-1:0]   cur_lvl
);
  localparam logic [AW-1:0] STEP_PC = AW'(4);
  localparam logic [AW-1:0] STEP_SR = AW'(2);

  seq_st_t         st;
  logic [VW-1:0]   vec_q;
  logic            from_irq;
  logic [AW-1:0]   vbr_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= SQ_IDLE;
      sr_q     <= SR_AT_RESET;
      pc_q     <= '0;
      sp_q     <= '0;
      vbr_q    <= '0;
      cur_lvl  <= '0;
      vec_q    <= '0;
      from_irq <= 1'b0;
    end else begin
      case (st)
        SQ_IDLE: begin
          if (exc_req) begin
            vec_q    <= VW'(exc_vector(exc_kind, exc_arg));
            from_irq <= 1'b0;
            st       <= SQ_SAVE_PC;
          end else if (take_irq) begin
            cur_lvl  <= pend_lvl;
            from_irq <= 1'b1;
            st       <= SQ_ACK;
          end else if (ld_en) begin
            sr_q    <= ld_sr;
            pc_q    <= ld_pc;
            sp_q    <= ld_sp;
            vbr_q   <= ld_vbr;
            cur_lvl <= ld_lvl;
          end
        end
        SQ_ACK: begin
          if (ack_done) begin
            vec_q <= ack_vec;
            st    <= SQ_SAVE_PC;
          end
        end
        SQ_SAVE_PC: begin
          if (mem_ack) begin
            sp_q <= sp_q - STEP_PC;
            st   <= SQ_SAVE_SR;
          end
        end
        SQ_SAVE_SR: begin
          if (mem_ack) begin
            sp_q          <= sp_q - STEP_SR;
            sr_q[SR_SUP]  <= 1'b1;
            sr_q[SR_STEP] <= 1'b0;
            if (from_irq) sr_q[SR_MLO +: LW] <= cur_lvl;
            st <= SQ_VFETCH;
          end
        end
        SQ_VFETCH: begin
          if (mem_ack) begin
            pc_q <= mem_rdata;
            st   <= SQ_IDLE;
          end
        end
        default: st <= SQ_IDLE;
      endcase
    end
  end

  // Outputs depend on state registers only
  always_comb begin
    busy      = (st != SQ_IDLE);
    ack_req   = (st == SQ_ACK);
    ack_lvl   = cur_lvl;
    mem_req   = 1'b0;
    mem_we    = 1'b0;
    mem_long  = 1'b1;
    mem_addr  = '0;
    mem_wdata = '0;
    case (st)
      SQ_SAVE_PC: begin
        mem_req   = 1'b1;
        mem_we    = 1'b1;
        mem_addr  = sp_q - STEP_PC;
        mem_wdata = pc_q;
      end
      SQ_SAVE_SR: begin
        mem_req   = 1'b1;
        mem_we    = 1'b1;
        mem_long  = 1'b0;
        mem_addr  = sp_q - STEP_SR;
        mem_wdata = AW'(sr_q);
      end
      SQ_VFETCH: begin
        mem_req   = 1'b1;
        mem_addr  = vbr_q + AW'({vec_q, 2'b00});
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/irq_entry_seq.sv
module irq_entry_seq
  import irq_entry_pkg::*;
#(
  parameter int AW = 32,
  parameter int LW = 3,
  parameter int VW = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [LW-1:0]   pend_lvl,
  output logic            ack_req,
  output logic [LW-1:0]   ack_lvl,
  input  logic            ack_done,
  input  logic [VW-1:0]   ack_vec,
  input  logic            exc_req,
  input  logic [1:0]      exc_kind,
  input  logic [3:0]      exc_arg,
  output logic            mem_req,
  output logic            mem_we,
  output logic            mem_long,
  output logic [AW-1:0]   mem_addr,
  output logic [AW-1:0]   mem_wdata,
  input  logic [AW-1:0]   mem_rdata,
  input  logic            mem_ack,
  input  logic            ld_en,
  input  logic [SR_W-1:0] ld_sr,
  input  logic [AW-1:0]   ld_pc,
  input  logic [AW-1:0]   ld_sp,
  input  logic [AW-1:0]   ld_vbr,
  input  logic [LW-1:0]   ld_lvl,
  output logic            busy,
  output logic [SR_W-1:0] sr_q,
  output logic [AW-1:0]   pc_q,
  output logic [AW-1:0]   sp_q,
  output logic [LW-1:0]   cur_lvl
);
  logic take_irq;

  irq_accept #(.LW(LW)) u_accept (
    .pend     (pend_lvl),
    .mask     (sr_q[SR_MLO +: LW]),
    .serviced (cur_lvl),
    .take     (take_irq)
  );

  entry_fsm #(.AW(AW), .LW(LW), .VW(VW)) u_fsm (
    .clk       (clk),
    .rst       (rst),
    .take_irq  (take_irq),
    .pend_lvl  (pend_lvl),
    .exc_req   (exc_req),
    .exc_kind  (exc_kind),
    .exc_arg   (exc_arg),
    .ack_done  (ack_done),
    .ack_vec   (ack_vec),
    .mem_ack   (mem_ack),
    .mem_rdata (mem_rdata),
    .ld_en     (ld_en),
    .ld_sr     (ld_sr),
    .ld_pc     (ld_pc),
    .ld_sp     (ld_sp),
    .ld_vbr    (ld_vbr),
    .ld_lvl    (ld_lvl),
    .busy      (busy),
    .ack_req   (ack_req),
    .ack_lvl   (ack_lvl),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_long  (mem_long),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .sr_q      (sr_q),
    .pc_q      (pc_q),
    .sp_q      (sp_q),
    .cur_lvl   (cur_lvl)
  );
endmodule

// File: rtl/irq_entry_chk.sv
module irq_entry_chk
  import irq_entry_pkg::*;
#(
  parameter int AW = 32,
  parameter int LW = 3
) (
  input logic            clk,
  input logic            rst,
  input logic            busy,
  input logic            ack_req,
  input logic [LW-1:0]   ack_lvl,
  input logic [LW-1:0]   cur_lvl,
  input logic            mem_req,
  input logic            mem_we,
  input logic            mem_long,
  input logic            mem_ack,
  input logic [SR_W-1:0] sr_q,
  input logic [AW-1:0]   pc_q
);
  // R9: the controller is only asked during an entry
  p_ack_in_busy_r9: assert property (@(posedge clk) disable iff (rst)
    ack_req |-> busy);

  // R2: the acknowledged level is the one now being serviced
  p_ack_lvl_r2: assert property (@(posedge clk) disable iff (rst)
    ack_req |-> (ack_lvl == cur_lvl));

  // R9: the serviced level does not move once an entry is under way
  p_lvl_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy)) |-> $stable(cur_lvl));

  // R4: the status word is untouched while the return address is stacked
  p_sr_hold_r4: assert property (@(posedge clk) disable iff (rst)
    (mem_req && mem_we && mem_long) |-> $stable(sr_q));

  // R5: privileged set and single-step cleared right after the status write
  p_flags_after_r5: assert property (@(posedge clk) disable iff (rst)
    (mem_req && mem_we && !mem_long && mem_ack) |=>
      (sr_q[SR_SUP] && !sr_q[SR_STEP]));

  // R9: the program counter only changes with the vector read
  p_pc_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (busy && !(mem_req && !mem_we && mem_ack)) |=> $stable(pc_q));

  // R7: an entry ends only on a completed vector read
  p_end_on_fetch_r7: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> $past(mem_req && !mem_we && mem_ack));
endmodule

bind irq_entry_seq irq_entry_chk #(.AW(AW), .LW(LW)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .busy     (busy),
  .ack_req  (ack_req),
  .ack_lvl  (ack_lvl),
  .cur_lvl  (cur_lvl),
  .mem_req  (mem_req),
  .mem_we   (mem_we),
  .mem_long (mem_long),
  .mem_ack  (mem_ack),
  .sr_q     (sr_q),
  .pc_q     (pc_q)
);

// File: tb/sim_irq_entry_seq.sv
`timescale 1ns/1ps
module sim_irq_entry_seq;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [2:0]  pend_lvl;
  logic        ack_req;
  logic [2:0]  ack_lvl;
  logic        ack_done = 1'b0;
  logic [7:0]  ack_vec = 8'd0;
  logic        exc_req = 1'b0;
  logic [1:0]  exc_kind = 2'd0;
  logic [3:0]  exc_arg = 4'd0;
  logic        mem_req, mem_we, mem_long;
  logic [31:0] mem_addr, mem_wdata;
  logic [31:0] mem_rdata = 32'd0;
  logic        mem_ack = 1'b0;
  logic        ld_en = 1'b0;
  logic [15:0] ld_sr = 16'd0;
  logic [31:0] ld_pc = 32'd0, ld_sp = 32'd0, ld_vbr = 32'd0;
  logic [2:0]  ld_lvl = 3'd0;
  logic        busy;
  logic [15:0] sr_q;
  logic [31:0] pc_q, sp_q;
  logic [2:0]  cur_lvl;

  always #4 clk = ~clk;

  int tests = 0;
  int fails = 0;

  typedef struct {
    logic        we;
    logic        lng;
    logic [31:0] addr;
    logic [31:0] data;
    string       tag;
  } xfer_t;
  xfer_t exp_q[$];

  // controller model state
  logic [2:0] want_lvl = 3'd0;
  logic [2:0] exp_ack_lvl = 3'd0;
  logic [7:0] exp_ack_vec = 8'd0;
  int ack_cnt = 0;
  int ack_base = 0;
  assign pend_lvl = (ack_cnt != ack_base) ? 3'd0 : want_lvl;

  irq_entry_seq u0 (.*);

  task automatic chk(input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Monitor: memory and controller model, scoreboard compare
  always @(negedge clk) begin
    mem_ack  = 1'b0;
    ack_done = 1'b0;
    if (!rst && mem_req) begin
      if (exp_q.size() == 0) begin
        chk("R9 unexpected transfer addr", mem_addr, 32'hFFFF_FFFF);
      end else begin
        xfer_t it;
        it = exp_q.pop_front();
        chk({it.tag, " we"}, {31'd0, mem_we}, {31'd0, it.we});
        chk({it.tag, " size"}, {31'd0, mem_long}, {31'd0, it.lng});
        chk({it.tag, " addr"}, mem_addr, it.addr);
        if (it.we) begin
          if (it.lng) chk({it.tag, " data"}, mem_wdata, it.data);
          else        chk({it.tag, " data"}, {16'd0, mem_wdata[15:0]}, it.data);
        end
        mem_rdata = it.we ? 32'd0 : it.data;
      end
      mem_ack = 1'b1;
    end
    if (!rst && ack_req) begin
      chk("R2 ack level", {29'd0, ack_lvl}, {29'd0, exp_ack_lvl});
      ack_vec  = exp_ack_vec;
      ack_done = 1'b1;
      ack_cnt++;
    end
  end

  // Driver helpers
  task automatic load(input logic [15:0] sr, input logic [31:0] pc,
                      input logic [31:0] sp, input logic [31:0] vbr,
                      input logic [2:0] lvl);
    @(negedge clk);
    ld_en = 1'b1; ld_sr = sr; ld_pc = pc; ld_sp = sp; ld_vbr = vbr; ld_lvl = lvl;
    @(negedge clk);
    ld_en = 1'b0;
  endtask

  task automatic expect_entry(input string tag, input logic [31:0] pc,
                              input logic [15:0] sr, input logic [31:0] sp,
                              input logic [31:0] vbr, input logic [7:0] vec,
                              input logic [31:0] newpc);
    exp_q.push_back('{1'b1, 1'b1, sp - 32'd4, pc, {tag, " R4 pc save"}});
    exp_q.push_back('{1'b1, 1'b0, sp - 32'd6, {16'd0, sr}, {tag, " R4 sr save"}});
    exp_q.push_back('{1'b0, 1'b1, vbr + {22'd0, vec, 2'b00}, newpc, {tag, " R7 vector read"}});
  endtask

  task automatic raise(input logic [2:0] lvl, input logic [7:0] vec);
    @(negedge clk);
    exp_ack_lvl = lvl;
    exp_ack_vec = vec;
    ack_base    = ack_cnt;
    want_lvl    = lvl;
  endtask

  task automatic pulse_exc(input logic [1:0] kind, input logic [3:0] arg);
    @(negedge clk);
    exc_req = 1'b1; exc_kind = kind; exc_arg = arg;
    @(negedge clk);
    exc_req = 1'b0;
  endtask

  task automatic wait_done();
    for (int i = 0; i < 60; i++) begin
      @(negedge clk);
      if (exp_q.size() == 0 && !busy) break;
    end
    chk("R7 scoreboard drained", exp_q.size(), 0);
    want_lvl = 3'd0;
  endtask

  task automatic reject(input logic [2:0] lvl, input string tag);
    logic seen;
    int   base;
    seen = 1'b0;
    @(negedge clk);
    base     = ack_cnt;
    ack_base = ack_cnt;
    want_lvl = lvl;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      if (busy || ack_req) seen = 1'b1;
    end
    chk({tag, " busy/ack stayed low"}, {31'd0, seen}, 32'd0);
    chk({tag, " no acknowledge"}, ack_cnt - base, 0);
    want_lvl = 3'd0;
  endtask

  task automatic state_is(input string tag, input logic [15:0] sr,
                          input logic [31:0] pc, input logic [31:0] sp,
                          input logic [2:0] lvl);
    chk({tag, " sr"}, {16'd0, sr_q}, {16'd0, sr});
    chk({tag, " pc"}, pc_q, pc);
    chk({tag, " sp"}, sp_q, sp);
    chk({tag, " level"}, {29'd0, cur_lvl}, {29'd0, lvl});
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    fails++;
    tests++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin : main
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    state_is("R1 reset", 16'h2700, 32'd0, 32'd0, 3'd0);
    chk("R1 busy", {31'd0, busy}, 32'd0);
    chk("R1 ack_req", {31'd0, ack_req}, 32'd0);
    chk("R1 mem_req", {31'd0, mem_req}, 32'd0);

    // R11 load, R3 at mask
    load(16'h0300, 32'h1000, 32'h8000, 32'h0, 3'd0);
    state_is("R11 load", 16'h0300, 32'h1000, 32'h8000, 3'd0);
    reject(3'd3, "R3 level equal to mask");
    reject(3'd2, "R3 level below mask");

    // R2 R6 interrupt above mask
    expect_entry("irq4", 32'h1000, 16'h0300, 32'h8000, 32'h0, 8'h40, 32'h2000);
    raise(3'd4, 8'h40);
    wait_done();
    state_is("R6 irq4 end", 16'h2400, 32'h2000, 32'h7FFA, 3'd4);

    // R3 below serviced level, then R2 equal to serviced level
    load(16'h0000, 32'h3000, 32'h9000, 32'h400, 3'd5);
    reject(3'd4, "R3 below serviced level");
    expect_entry("irq5", 32'h3000, 16'h0000, 32'h9000, 32'h400, 8'h45, 32'h5000);
    raise(3'd5, 8'h45);
    wait_done();
    state_is("R2 irq5 end", 16'h2500, 32'h5000, 32'h8FFA, 3'd5);

    // R2 level 7 passes a full mask
    load(16'h2700, 32'h6000, 32'hA000, 32'h0, 3'd4);
    expect_entry("irq7", 32'h6000, 16'h2700, 32'hA000, 32'h0, 8'h1F, 32'h7000);
    raise(3'd7, 8'h1F);
    wait_done();
    state_is("R2 irq7 end", 16'h2700, 32'h7000, 32'h9FFA, 3'd7);

    // R8 trap vector, R5 mask kept, R9 requests and loads ignored while busy
    load(16'h8205, 32'h400, 32'h1000, 32'h10000, 3'd0);
    expect_entry("trap3", 32'h400, 16'h8205, 32'h1000, 32'h10000, 8'd35, 32'h8800);
    pulse_exc(2'd0, 4'd3);
    chk("R9 busy after request", {31'd0, busy}, 32'd1);
    ld_en = 1'b1; ld_sp = 32'hDEAD0; ld_sr = 16'h0000; ld_pc = 32'h0;
    exc_req = 1'b1; exc_kind = 2'd2;
    @(negedge clk);
    ld_en = 1'b0; exc_req = 1'b0;
    wait_done();
    state_is("R5 trap end", 16'h2205, 32'h8800, 32'h0FFA, 3'd0);
    begin
      logic seen;
      seen = 1'b0;
      for (int i = 0; i < 4; i++) begin
        @(negedge clk);
        if (busy) seen = 1'b1;
      end
      chk("R9 ignored request started nothing", {31'd0, seen}, 32'd0);
      chk("R9 ignored load left sp", sp_q, 32'h0FFA);
    end

    // R8 zero divisor vector
    load(16'h0000, 32'h100, 32'h2000, 32'h0, 3'd0);
    expect_entry("zdiv", 32'h100, 16'h0000, 32'h2000, 32'h0, 8'd5, 32'h900);
    pulse_exc(2'd1, 4'd0);
    wait_done();
    state_is("R8 zero divisor end", 16'h2000, 32'h900, 32'h1FFA, 3'd0);

    // R10 exception wins over a same-cycle interrupt, which follows
    load(16'h0100, 32'hA00, 32'h3000, 32'h0, 3'd0);
    expect_entry("ovfl", 32'hA00, 16'h0100, 32'h3000, 32'h0, 8'd7, 32'hB00);
    expect_entry("irq6", 32'hB00, 16'h2100, 32'h2FFA, 32'h0, 8'h46, 32'hC00);
    @(negedge clk);
    exp_ack_lvl = 3'd6; exp_ack_vec = 8'h46; ack_base = ack_cnt; want_lvl = 3'd6;
    exc_req = 1'b1; exc_kind = 2'd2; exc_arg = 4'd0;
    @(negedge clk);
    exc_req = 1'b0;
    wait_done();
    state_is("R10 both entries end", 16'h2600, 32'hC00, 32'h2FF4, 3'd6);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule